// File: doc/BRIEF.md
# Rotate-and-combine custom instruction execute unit

This unit sits next to the ALU of a small RV32E processor and handles two extra register-to-register instructions that speed up an add-rotate-xor block cipher. It looks at the 32-bit instruction word. When the word is one of the two instructions, it raises a match flag. It also reports the destination register index and produces the 32-bit result from the two source operand values that the core has already read.

Both instructions use the R-type layout under the custom-0 major opcode, 0x0B. The funct3 field chooses the operation:

- funct3 = 000: the first operand is rotated right by 8 bits and then added to the second operand. The sum wraps modulo 2^32.
- funct3 = 001: the first operand is rotated left by 3 bits and then XORed with the second operand.

The funct7 field is never decoded. The unit is purely combinational, so the core can write the result back in the same cycle as its own ALU results.

Top module: `ck_cipher_ex`

## Requirements
- R1: `hit_o` is 1 exactly when insn_i[6:0] equals 7'h0B and insn_i[14:12] is 3'b000 or 3'b001.
- R2: With funct3 = 3'b000, `result_o` equals (rs1 rotated right by 8) + rs2, truncated to 32 bits. For example, rs1 = 0xFFFFFFFF with rs2 = 1 gives 0.
- R3: With funct3 = 3'b001, `result_o` equals (rs1 rotated left by 3) XOR rs2.
- R4: The funct7 field, insn_i[31:25], has no effect on any output.
- R5: Under opcode 0x0B, any funct3 value other than 000 and 001 drives `hit_o` to 0.
- R6: On a match, `rd_idx_o` equals insn_i[10:7]. Bit 11 of the rd field is ignored, because the core has 16 registers.
- R7: When `hit_o` is 0, both `result_o` and `rd_idx_o` are 0.
- R8: The source index fields, insn_i[24:15], do not change `result_o` or `hit_o`. Operand data comes only from `rs1_val_i` and `rs2_val_i`.
- R9: The outputs follow the inputs within the same cycle, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word being executed |
| rs1_val_i | input | 32 | Value of the first source register |
| rs2_val_i | input | 32 | Value of the second source register |
| hit_o | output | 1 | The word is one of the two custom instructions |
| rd_idx_o | output | 4 | Destination register index |
| result_o | output | 32 | Result to write back |

## Verification
The unit holds no state, so any fault shows at the ports in the same evaluation as the stimulus that exposes it.

- A wrong rotation amount or direction corrupts the result for almost any operand value.
- A missing carry shows only when a carry crosses a byte lane, so sums near the 32-bit wrap are applied directly.
- A decoder that looks at funct7, at the register index fields or at bit 11 of rd produces a result, flag or index that differs between words that should be equivalent.

The bench therefore compares pairs of such words against each other as well as against the reference model.

// File: rtl/ck_pkg.sv
package ck_pkg;
    localparam logic [6:0] OPC_CUSTOM0 = 7'h0B;
    localparam logic [2:0] F3_ROR_ADD  = 3'b000;
    localparam logic [2:0] F3_ROL_XOR  = 3'b001;
    localparam int         IDX_W       = 4;

    typedef enum logic [0:0] {
        OP_ROR_ADD = 1'b0,
        OP_ROL_XOR = 1'b1
    } op_e;

    typedef struct packed {
        logic             hit;
        op_e              op;
        logic [IDX_W-1:0] rd;
    } dec_t;
endpackage

// File: rtl/ck_decode.sv
module ck_decode
    import ck_pkg::*;
(
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);
    logic [6:0] opc;
    logic [2:0] f3;

    assign opc = insn_i[6:0];
    assign f3  = insn_i[14:12];

    always_comb begin
        dec_o    = '0;
        dec_o.op = OP_ROR_ADD;
        if (opc == OPC_CUSTOM0) begin
            unique case (f3)
                F3_ROR_ADD: begin
                    dec_o.hit = 1'b1;
                    dec_o.op  = OP_ROR_ADD;
                end
                F3_ROL_XOR: begin
                    dec_o.hit = 1'b1;
                    dec_o.op  = OP_ROL_XOR;
                end
                default: dec_o.hit = 1'b0;
            endcase
        end
        if (dec_o.hit) begin
            dec_o.rd = insn_i[7 +: IDX_W];
        end
    end

    always_comb begin
        // R5
        if (opc == OPC_CUSTOM0 && f3[2:1] != 2'b00) begin
            other_f3_chk: assert (!dec_o.hit);
        end
    end
endmodule

// File: rtl/ck_exec.sv
module ck_exec
    import ck_pkg::*;
#(
    parameter int W       = 32,
    parameter int ROR_AMT = 8,
    parameter int ROL_AMT = 3
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    localparam int RR = ROR_AMT % W;
    localparam int RL = ROL_AMT % W;

    logic [W-1:0]   a_ror;
    logic [W-1:0]   a_rol;
    logic [2*W-1:0] dbl;

    assign dbl = {a_i, a_i};

    generate
        if (RR == 0) begin : g_ror_none
            assign a_ror = a_i;
        end else begin : g_ror_rot
            assign a_ror = dbl[RR +: W];
        end
        if (RL == 0) begin : g_rol_none
            assign a_rol = a_i;
        end else begin : g_rol_rot
            assign a_rol = dbl[W-RL +: W];
        end
    endgenerate

    always_comb begin
        unique case (op_i)
            OP_ROR_ADD: y_o = a_ror + b_i;
            OP_ROL_XOR: y_o = a_rol ^ b_i;
            default:    y_o = '0;
        endcase
    end
endmodule

// File: rtl/ck_cipher_ex.sv
module ck_cipher_ex
    import ck_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ROR_AMT = 8,
    parameter int ROL_AMT = 3
) (
    input  logic [31:0]      insn_i,
    input  logic [XLEN-1:0]  rs1_val_i,
    input  logic [XLEN-1:0]  rs2_val_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic [XLEN-1:0]  result_o
);
    dec_t            dec;
    logic [XLEN-1:0] raw;

    ck_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    ck_exec #(
        .W       (XLEN),
        .ROR_AMT (ROR_AMT),
        .ROL_AMT (ROL_AMT)
    ) u_exe (
        .op_i (dec.op),
        .a_i  (rs1_val_i),
        .b_i  (rs2_val_i),
        .y_o  (raw)
    );

    assign hit_o    = dec.hit;
    assign rd_idx_o = dec.rd;
    assign result_o = dec.hit ? raw : '0;

    function automatic logic [XLEN-1:0] rot_l(input logic [XLEN-1:0] x, input int n);
        logic [2*XLEN-1:0] d;
        d = {x, x} << (n % XLEN);
        return d[2*XLEN-1 -: XLEN];
    endfunction

    always_comb begin
        // R1
        if (hit_o) begin
            hit_opc_chk: assert (insn_i[6:0] == OPC_CUSTOM0);
        end
        // R7
        if (!hit_o) begin
            quiet_miss_chk: assert (result_o == '0 && rd_idx_o == '0);
        end
        // R6
        if (hit_o) begin
            rd_field_chk: assert (rd_idx_o == insn_i[10:7]);
        end
        // R2
        if (hit_o && insn_i[14:12] == F3_ROR_ADD) begin
            add_inverse_chk: assert (rot_l(result_o - rs2_val_i, ROR_AMT) == rs1_val_i);
        end
        // R3
        if (hit_o && insn_i[14:12] == F3_ROL_XOR) begin
            xor_inverse_chk: assert (rot_l(result_o ^ rs2_val_i, XLEN - (ROL_AMT % XLEN)) == rs1_val_i);
        end
    end
endmodule

// File: tb/tb_ck_cipher_ex.sv
module tb_ck_cipher_ex;
    logic        clk = 1'b0;
    logic [31:0] insn;
    logic [31:0] a;
    logic [31:0] b;
    logic        hit;
    logic [3:0]  rd;
    logic [31:0] res;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ck_cipher_ex dut (
        .insn_i    (insn),
        .rs1_val_i (a),
        .rs2_val_i (b),
        .hit_o     (hit),
        .rd_idx_o  (rd),
        .result_o  (res)
    );

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] s2,
                                       input logic [4:0] s1, input logic [2:0] f3,
                                       input logic [4:0] d, input logic [6:0] opc);
        return {f7, s2, s1, f3, d, opc};
    endfunction

    function automatic logic [31:0] ref_res(input logic [31:0] w, input logic [31:0] x,
                                            input logic [31:0] y);
        if (w[6:0] != 7'h0B) return 32'h0;
        if (w[14:12] == 3'b000) return ((x >> 8) | (x << 24)) + y;
        if (w[14:12] == 3'b001) return ((x << 3) | (x >> 29)) ^ y;
        return 32'h0;
    endfunction

    function automatic logic ref_hit(input logic [31:0] w);
        return (w[6:0] == 7'h0B) && (w[14:13] == 2'b00);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h insn=%h", tag, act, exp, insn);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [31:0] x, input logic [31:0] y);
        @(negedge clk);
        insn = w;
        a    = x;
        b    = y;
        #5;
    endtask

    task automatic full(input string tag, input logic [31:0] w, input logic [31:0] x,
                        input logic [31:0] y);
        logic h;
        apply(w, x, y);
        h = ref_hit(w);
        chk({tag, " R1 hit"}, {31'b0, hit}, {31'b0, h});
        chk({tag, " R2/R3 result"}, res, ref_res(w, x, y));
        chk({tag, " R6 rd"}, {28'b0, rd}, h ? {28'b0, w[10:7]} : 32'h0);
    endtask

    typedef struct packed {
        logic [31:0] w;
        logic [31:0] x;
        logic [31:0] y;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_050B, 32'h1234_5678, 32'h0000_0000},
        '{32'h0000_150B, 32'h8000_0001, 32'h0000_0000},
        '{32'h0000_058B, 32'hFFFF_FFFF, 32'h0000_0001},
        '{32'hFE00_150B, 32'hDEAD_BEEF, 32'hCAFE_F00D},
        '{32'h0000_250B, 32'h1111_1111, 32'h2222_2222},
        '{32'h0000_750B, 32'h1111_1111, 32'h2222_2222},
        '{32'h0000_0033, 32'h1234_5678, 32'h1111_1111},
        '{32'h0000_008B, 32'h0000_00FF, 32'hFFFF_FF00},
        '{32'h0000_1F0B, 32'h7FFF_FFFF, 32'hFFFF_FFFF},
        '{32'h0000_002B, 32'hAAAA_AAAA, 32'h5555_5555}
    };

    initial begin
        insn = '0;
        a    = '0;
        b    = '0;
        #5;
        // R7 idle state with an all-zero instruction word
        chk("R7 idle hit", {31'b0, hit}, 32'h0);
        chk("R7 idle result", res, 32'h0);
        chk("R7 idle rd", {28'b0, rd}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            full("table", VECS[i].w, VECS[i].x, VECS[i].y);
        end

        // R2 directed values
        apply(mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd5, 7'h0B), 32'h1234_5678, 32'h0);
        chk("R2 ror8", res, 32'h7812_3456);
        apply(mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd5, 7'h0B), 32'hFFFF_FFFF, 32'h1);
        chk("R2 wrap", res, 32'h0);
        apply(mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd5, 7'h0B), 32'h0000_FF00, 32'h0000_0001);
        chk("R2 carry chain", res, 32'h0000_0100);
        // R3 directed value
        apply(mk(7'h00, 5'd2, 5'd1, 3'b001, 5'd5, 7'h0B), 32'h8000_0001, 32'h0000_0005);
        chk("R3 rol3", res, 32'h0000_0009);

        // R5 every other funct3 value
        for (int f = 2; f < 8; f++) begin
            apply(mk(7'h00, 5'd2, 5'd1, 3'(f), 5'd6, 7'h0B), 32'h1234_5678, 32'h9ABC_DEF0);
            chk("R5 other funct3 hit", {31'b0, hit}, 32'h0);
            chk("R7 other funct3 result", res, 32'h0);
        end

        // R6 bit 11 of rd ignored
        apply(mk(7'h00, 5'd2, 5'd1, 3'b001, 5'h1A, 7'h0B), 32'h1, 32'h2);
        chk("R6 rd bit 11", {28'b0, rd}, 32'hA);

        // R4 and R8 random operands, compare against a variant with funct7 and
        // index fields changed
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w1;
            logic [31:0] w2;
            logic [31:0] x;
            logic [31:0] y;
            logic [31:0] r1;
            logic        h1;
            logic [3:0]  d1;
            x  = $urandom;
            y  = $urandom;
            w1 = $urandom;
            if (i % 4 != 3) w1[6:0] = 7'h0B;
            if (i % 2 == 0) w1[14:13] = 2'b00;
            full("R2/R3 random", w1, x, y);
            r1 = res;
            h1 = hit;
            d1 = rd;
            w2 = w1;
            w2[31:25] = 7'($urandom);
            w2[24:15] = 10'($urandom);
            apply(w2, x, y);
            chk("R4/R8 result", res, r1);
            chk("R4/R8 hit", {31'b0, hit}, {31'b0, h1});
            chk("R4 rd", {28'b0, rd}, {28'b0, d1});
        end

        // R9 outputs change with no clock edge in between
        @(negedge clk);
        insn = mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'h0B);
        a    = 32'h0000_0100;
        b    = 32'h0000_0001;
        #1;
        chk("R9 settle 1", res, 32'h0000_0002);
        a = 32'h0000_0200;
        #1;
        chk("R9 settle 2", res, 32'h0000_0003);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule